// File: doc/BRIEF.md
# Privileged Instruction Trap Unit

This unit sits at the retire point of a processor pipeline. Each cycle it receives a decoded instruction-class vector, the PC of the instruction that retires, and a retire-valid strobe. When one of six supervisor-only operations retires while the core runs in user mode with traps enabled, the unit takes a privileged-instruction exception. In the cycle after retire it writes a fixed exception status word, saves the faulting PC, marks the status record as active, loads the trap-type field of the trap base register, switches the core to supervisor mode with traps disabled, and redirects fetch to the handler. The handler address is the trap base with the trap type times 16 added, which is offset 0x060.

The unit holds its own mode/control register, trap base register, exception status, exception PC, status-active flag and PC-save register. Software reads and writes them through a small select/data port. A return-from-trap retired in supervisor mode restores the saved mode, enables traps again and resumes at the PC-save register, which the handler may have advanced. A privileged operation that arrives while traps are disabled cannot be taken. The unit then pulses an error output and leaves every register alone.

Top module: `priv_trap_unit`

## Requirements
- R1: Retire-class bits 0 to 5 mark the privileged operations: 0 return-from-trap, 1 return-from-exception, 2 instruction TLB write, 3 data TLB write, 4 instruction TLB invalidate, 5 data TLB invalidate. Any of these bits that retires with control bit 2 (supervisor) at 0 and control bit 0 (trap enable) at 1 takes the trap.
- R2: In the cycle after a trapping retire, `redirect_valid` is 1 and `redirect_pc` equals trap base bits 31:12 concatenated with trap type 0x06 in bits 11:4 and zero in bits 3:0. The trap base register (select 1) reads back with bits 11:4 equal to 0x06.
- R3: After a trap, the exception status register (select 2) reads 0x00000009: bit 0 valid = 1, bits 5:1 code = 4, and bit 11 address-valid = 0.
- R4: After a trap, both the exception PC register (select 3) and the PC-save register (select 5) hold the PC of the faulting instruction itself.
- R5: After a trap, bit 0 of the status-active flag register (select 4) is 1.
- R6: A trap sets control bit 2 (supervisor) to 1, copies the old supervisor bit into control bit 1, and clears control bit 0. `mode_super` and `mode_trap_en` follow these bits.
- R7: No trap and no error occur when supervisor mode is set, when only non-privileged class bits (6 and up) are set, or when `retire_valid` is 0.
- R8: A privileged retire in user mode with trap enable at 0 pulses `trap_err` for one cycle. It does not redirect and changes no register.
- R9: A return-from-trap (class bit 0) retired in supervisor mode redirects to the PC-save value in the next cycle. It also sets the supervisor bit from control bit 1 and sets trap enable to 1.
- R10: A software write lands at the selected register on the clock edge. `reg_rdata` returns the selected register one cycle after the select. When a trap and a software write hit the same register in the same cycle, the trap value is kept.
- R11: After reset the control register reads 0x4 (supervisor, traps off), all other registers read 0, and `redirect_valid` and `trap_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_valid | input | 1 | An instruction retires this cycle |
| retire_class | input | NCLS | Decoded class vector of the retiring instruction |
| retire_pc | input | XLEN | PC of the retiring instruction |
| reg_wr_en | input | 1 | Software register write strobe |
| reg_sel | input | 3 | Register select: 0 control, 1 trap base, 2 exc status, 3 exc PC, 4 active flag, 5 PC save |
| reg_wdata | input | XLEN | Software write data |
| reg_rdata | output | XLEN | Registered read data of the selected register |
| redirect_valid | output | 1 | Fetch redirect strobe |
| redirect_pc | output | XLEN | Fetch redirect target |
| trap_err | output | 1 | Privileged op seen with traps disabled |
| mode_super | output | 1 | Current supervisor bit |
| mode_trap_en | output | 1 | Current trap-enable bit |

## Verification
The bench builds the unit with its defaults: a 32-bit data path, an eight-bit class vector whose low six bits are privileged, and trap type 0x06. With these values one trap base of 0x4000 gives a handler at 0x4060. The full trap-and-return round trip is run for each of the six privileged classes, with a non-privileged class bit, with supervisor mode and with traps disabled. Because the class vector is wider than the privileged mask, bits outside the mask can be shown to be ignored.

// File: rtl/ptu_pkg.sv
package ptu_pkg;
  // register select codes
  localparam logic [2:0] SEL_CTL    = 3'd0;
  localparam logic [2:0] SEL_TBASE  = 3'd1;
  localparam logic [2:0] SEL_XSTAT  = 3'd2;
  localparam logic [2:0] SEL_XPC    = 3'd3;
  localparam logic [2:0] SEL_XFLAG  = 3'd4;
  localparam logic [2:0] SEL_PCSAVE = 3'd5;

  // control register bit positions
  localparam int CTL_TE   = 0;
  localparam int CTL_PREV = 1;
  localparam int CTL_SUP  = 2;

  // exception status layout
  localparam int XS_VALID = 0;
  localparam int XS_CODE_LO = 1;
  localparam int XS_CODE_W  = 5;
  localparam int XS_ADDRV = 11;

  // trap base layout
  localparam int TB_TT_LO = 4;
  localparam int TB_TT_W  = 8;
  localparam int TB_BASE_LO = TB_TT_LO + TB_TT_W;

  typedef struct packed {
    logic sup;
    logic prev;
    logic te;
  } ctl_t;
endpackage

// File: rtl/ptu_classify.sv
module ptu_classify #(
  parameter int NCLS = 8,
  parameter logic [NCLS-1:0] PRIV_MASK = 8'h3F,
  parameter int RET_BIT = 0
) (
  input  logic            valid,
  input  logic [NCLS-1:0] cls,
  output logic            priv_hit,
  output logic            ret_hit
);
  logic [NCLS-1:0] masked;

  for (genvar g = 0; g < NCLS; g++) begin : g_mask
    if (PRIV_MASK[g]) begin : g_on
      assign masked[g] = cls[g];
    end else begin : g_off
      assign masked[g] = 1'b0;
    end
  end

  assign priv_hit = valid & (|masked);
  assign ret_hit  = valid & cls[RET_BIT];
endmodule

// File: rtl/ptu_ctrl.sv
module ptu_ctrl
  import ptu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [7:0] TT_PRIV = 8'h06,
  localparam int BASE_W = XLEN - TB_BASE_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              priv_hit,
  input  logic              ret_hit,
  input  logic [BASE_W-1:0] tbase_hi,
  input  logic [XLEN-1:0]   pcsave,
  input  logic              ctl_wr,
  input  logic [2:0]        ctl_wdata,
  output logic              take_trap,
  output ctl_t              ctl_q,
  output logic              redirect_valid,
  output logic [XLEN-1:0]   redirect_pc,
  output logic              trap_err
);
  logic take_ret, take_err;

  assign take_trap = priv_hit & ~ctl_q.sup & ctl_q.te;
  assign take_err  = priv_hit & ~ctl_q.sup & ~ctl_q.te;
  assign take_ret  = ret_hit & ctl_q.sup;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q          <= '{sup: 1'b1, prev: 1'b0, te: 1'b0};
      redirect_valid <= 1'b0;
      redirect_pc    <= '0;
      trap_err       <= 1'b0;
    end else begin
      redirect_valid <= take_trap | take_ret;
      trap_err       <= take_err;
      if (take_trap) begin
        ctl_q.prev  <= ctl_q.sup;
        ctl_q.sup   <= 1'b1;
        ctl_q.te    <= 1'b0;
        redirect_pc <= {tbase_hi, TT_PRIV, 4'b0000};
      end else if (take_ret) begin
        ctl_q.sup   <= ctl_q.prev;
        ctl_q.te    <= 1'b1;
        redirect_pc <= pcsave;
      end else if (ctl_wr) begin
        ctl_q.sup  <= ctl_wdata[CTL_SUP];
        ctl_q.prev <= ctl_wdata[CTL_PREV];
        ctl_q.te   <= ctl_wdata[CTL_TE];
      end
    end
  end
endmodule

// File: rtl/ptu_xregs.sv
module ptu_xregs
  import ptu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [7:0] TT_PRIV = 8'h06,
  parameter logic [4:0] CODE_PRIV = 5'd4,
  localparam int BASE_W = XLEN - TB_BASE_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_trap,
  input  logic [XLEN-1:0]   trap_pc,
  input  logic              wr_en,
  input  logic [2:0]        sel,
  input  logic [XLEN-1:0]   wdata,
  input  ctl_t              ctl_q,
  output logic [BASE_W-1:0] tbase_hi,
  output logic [XLEN-1:0]   pcsave,
  output logic [XLEN-1:0]   rdata
);
  logic [XLEN-1:0] tbase, xstat, xpc;
  logic            xflag;
  logic [XLEN-1:0] stat_word, ctl_word;

  always_comb begin
    stat_word = '0;
    stat_word[XS_VALID] = 1'b1;
    stat_word[XS_CODE_LO +: XS_CODE_W] = CODE_PRIV;
    stat_word[XS_ADDRV] = 1'b0;
    ctl_word = '0;
    ctl_word[CTL_SUP]  = ctl_q.sup;
    ctl_word[CTL_PREV] = ctl_q.prev;
    ctl_word[CTL_TE]   = ctl_q.te;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tbase  <= '0;
      xstat  <= '0;
      xpc    <= '0;
      xflag  <= 1'b0;
      pcsave <= '0;
    end else if (take_trap) begin
      tbase[TB_TT_LO +: TB_TT_W] <= TT_PRIV;
      xstat  <= stat_word;
      xpc    <= trap_pc;
      xflag  <= 1'b1;
      pcsave <= trap_pc;
    end else if (wr_en) begin
      case (sel)
        SEL_TBASE:  tbase  <= wdata;
        SEL_XSTAT:  xstat  <= wdata;
        SEL_XPC:    xpc    <= wdata;
        SEL_XFLAG:  xflag  <= wdata[0];
        SEL_PCSAVE: pcsave <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else begin
      case (sel)
        SEL_CTL:    rdata <= ctl_word;
        SEL_TBASE:  rdata <= tbase;
        SEL_XSTAT:  rdata <= xstat;
        SEL_XPC:    rdata <= xpc;
        SEL_XFLAG:  rdata <= {{(XLEN-1){1'b0}}, xflag};
        SEL_PCSAVE: rdata <= pcsave;
        default:    rdata <= '0;
      endcase
    end
  end

  assign tbase_hi = tbase[XLEN-1:TB_BASE_LO];
endmodule

// File: rtl/priv_trap_unit.sv
module priv_trap_unit
  import ptu_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int NCLS = 8,
  parameter logic [NCLS-1:0] PRIV_MASK = 8'h3F,
  parameter int RET_BIT = 0,
  parameter logic [7:0] TT_PRIV = 8'h06,
  parameter logic [4:0] CODE_PRIV = 5'd4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            retire_valid,
  input  logic [NCLS-1:0] retire_class,
  input  logic [XLEN-1:0] retire_pc,
  input  logic            reg_wr_en,
  input  logic [2:0]      reg_sel,
  input  logic [XLEN-1:0] reg_wdata,
  output logic [XLEN-1:0] reg_rdata,
  output logic            redirect_valid,
  output logic [XLEN-1:0] redirect_pc,
  output logic            trap_err,
  output logic            mode_super,
  output logic            mode_trap_en
);
  localparam int BASE_W = XLEN - TB_BASE_LO;

  logic              priv_hit, ret_hit, take_trap;
  ctl_t              ctl_q;
  logic [BASE_W-1:0] tbase_hi;
  logic [XLEN-1:0]   pcsave;

  ptu_classify #(.NCLS(NCLS), .PRIV_MASK(PRIV_MASK), .RET_BIT(RET_BIT)) u_cls (
    .valid(retire_valid), .cls(retire_class),
    .priv_hit(priv_hit), .ret_hit(ret_hit)
  );

  ptu_ctrl #(.XLEN(XLEN), .TT_PRIV(TT_PRIV)) u_ctrl (
    .clk(clk), .rst(rst), .priv_hit(priv_hit), .ret_hit(ret_hit),
    .tbase_hi(tbase_hi), .pcsave(pcsave),
    .ctl_wr(reg_wr_en && reg_sel == SEL_CTL), .ctl_wdata(reg_wdata[2:0]),
    .take_trap(take_trap), .ctl_q(ctl_q),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .trap_err(trap_err)
  );

  ptu_xregs #(.XLEN(XLEN), .TT_PRIV(TT_PRIV), .CODE_PRIV(CODE_PRIV)) u_xr (
    .clk(clk), .rst(rst), .take_trap(take_trap), .trap_pc(retire_pc),
    .wr_en(reg_wr_en), .sel(reg_sel), .wdata(reg_wdata), .ctl_q(ctl_q),
    .tbase_hi(tbase_hi), .pcsave(pcsave), .rdata(reg_rdata)
  );

  assign mode_super   = ctl_q.sup;
  assign mode_trap_en = ctl_q.te;
endmodule

// File: rtl/priv_trap_unit_chk.sv
module priv_trap_unit_chk #(
  parameter int XLEN = 32,
  parameter int NCLS = 8,
  parameter logic [NCLS-1:0] PRIV_MASK = 8'h3F,
  parameter int RET_BIT = 0,
  parameter logic [7:0] TT_PRIV = 8'h06
) (
  input logic            clk,
  input logic            rst,
  input logic            retire_valid,
  input logic [NCLS-1:0] retire_class,
  input logic            redirect_valid,
  input logic [XLEN-1:0] redirect_pc,
  input logic            trap_err,
  input logic            mode_super,
  input logic            mode_trap_en
);
  logic priv_in;
  assign priv_in = retire_valid && (|(retire_class & PRIV_MASK));

  p_redirect_r2: assert property (@(posedge clk) disable iff (rst)
    (priv_in && !mode_super && mode_trap_en) |=> (redirect_valid && redirect_pc[11:4] == TT_PRIV));

  p_mode_switch_r6: assert property (@(posedge clk) disable iff (rst)
    (priv_in && !mode_super && mode_trap_en) |=> (mode_super && !mode_trap_en));

  p_quiet_super_r7: assert property (@(posedge clk) disable iff (rst)
    (mode_super && !(retire_valid && retire_class[RET_BIT])) |=> (!redirect_valid && !trap_err));

  p_err_raise_r8: assert property (@(posedge clk) disable iff (rst)
    (priv_in && !mode_super && !mode_trap_en) |=> (trap_err && !redirect_valid));

  p_err_stable_r8: assert property (@(posedge clk) disable iff (rst)
    trap_err |-> ($stable(mode_super) && $stable(mode_trap_en)));

  p_return_r9: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && retire_class[RET_BIT] && mode_super) |=> (redirect_valid && mode_trap_en));
endmodule

bind priv_trap_unit priv_trap_unit_chk #(
  .XLEN(XLEN), .NCLS(NCLS), .PRIV_MASK(PRIV_MASK), .RET_BIT(RET_BIT), .TT_PRIV(TT_PRIV)
) u_chk (
  .clk(clk), .rst(rst), .retire_valid(retire_valid), .retire_class(retire_class),
  .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .trap_err(trap_err),
  .mode_super(mode_super), .mode_trap_en(mode_trap_en)
);

// File: tb/sim_priv_trap_unit.sv
module sim_priv_trap_unit;
  localparam int XLEN = 32;
  localparam int NCLS = 8;
  localparam int K_RV = 0, K_RPC = 1, K_ERR = 2, K_RD = 3;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            retire_valid = 1'b0;
  logic [NCLS-1:0] retire_class = '0;
  logic [XLEN-1:0] retire_pc = '0;
  logic            reg_wr_en = 1'b0;
  logic [2:0]      reg_sel = '0;
  logic [XLEN-1:0] reg_wdata = '0;
  logic [XLEN-1:0] reg_rdata, redirect_pc;
  logic            redirect_valid, trap_err, mode_super, mode_trap_en;

  priv_trap_unit u0 (.*);

  always #10 clk = ~clk;

  typedef struct {
    int          due;
    int          kind;
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t q[$];

  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every due expectation against the outputs
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      logic [31:0] act;
      e = q.pop_front();
      case (e.kind)
        K_RV:    act = {31'b0, redirect_valid};
        K_RPC:   act = redirect_pc;
        K_ERR:   act = {31'b0, trap_err};
        default: act = reg_rdata;
      endcase
      n_chk++;
      if (act !== e.val) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", e.tag, act, e.val);
      end
    end
  end

  task automatic expect_next(int kind, logic [31:0] val, string tag);
    q.push_back('{due: cyc + 1, kind: kind, val: val, tag: tag});
  endtask

  task automatic idle();
    retire_valid = 0; retire_class = '0; reg_wr_en = 0;
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    idle(); reg_wr_en = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(logic [2:0] sel, logic [31:0] exp, string tag);
    idle(); reg_sel = sel;
    expect_next(K_RD, exp, tag);
    @(negedge clk);
  endtask

  task automatic retire(logic [7:0] cls, logic [31:0] pc, logic rv, logic [31:0] rpc,
                        logic err, string tag);
    idle(); retire_valid = 1; retire_class = cls; retire_pc = pc;
    expect_next(K_RV, {31'b0, rv}, tag);
    if (rv) expect_next(K_RPC, rpc, tag);
    expect_next(K_ERR, {31'b0, err}, tag);
    @(negedge clk);
    idle();
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    expect_next(K_RV, 0, "R11 redirect");
    expect_next(K_ERR, 0, "R11 err");
    rd(3'd0, 32'h4, "R11 ctl");
    rd(3'd2, 32'h0, "R11 xstat");
    rd(3'd1, 32'h0, "R11 tbase");
    rd(3'd5, 32'h0, "R11 pcsave");

    wr(3'd1, 32'h0000_4000);
    wr(3'd0, 32'h1);                       // user, traps on
    rd(3'd0, 32'h1, "R10 ctl write");

    for (int i = 0; i < 6; i++) begin
      logic [31:0] pc;
      pc = 32'h100 + 32'(i) * 16;
      // R1 each privileged class traps; R2 handler vector
      retire(8'(1 << i), pc, 1'b1, 32'h0000_4060, 1'b0, "R1/R2 trap redirect");
      rd(3'd2, 32'h9, "R3 status word");
      rd(3'd3, pc, "R4 exception pc");
      rd(3'd5, pc, "R4 pc save");
      rd(3'd4, 32'h1, "R5 active flag");
      rd(3'd0, 32'h4, "R6 mode after trap");
      rd(3'd1, 32'h0000_4060, "R2 trap type field");
      // handler: clear tt, advance pc save, return
      wr(3'd1, 32'h0000_4060 & 32'hFFFF_F00F);
      wr(3'd5, pc + 4);
      wr(3'd4, 32'h0);
      retire(8'h01, 32'h4070, 1'b1, pc + 4, 1'b0, "R9 return redirect");
      rd(3'd0, 32'h1, "R9 mode restored");
    end

    // R7 non-privileged class in user mode
    retire(8'hC0, 32'h300, 1'b0, 0, 1'b0, "R7 non-priv class");
    rd(3'd4, 32'h0, "R7 no flag");
    // R7 retire_valid low
    idle(); retire_class = 8'h3F; retire_pc = 32'h304;
    expect_next(K_RV, 0, "R7 valid low");
    expect_next(K_ERR, 0, "R7 valid low err");
    @(negedge clk);
    idle();
    // R7 supervisor mode
    wr(3'd0, 32'h5);
    retire(8'h10, 32'h308, 1'b0, 0, 1'b0, "R7 super no trap");
    rd(3'd0, 32'h5, "R7 ctl unchanged");

    // R8 traps disabled in user mode
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0);
    retire(8'h08, 32'h500, 1'b0, 0, 1'b1, "R8 error pulse");
    expect_next(K_ERR, 0, "R8 pulse ends");
    rd(3'd2, 32'h0, "R8 status untouched");
    rd(3'd3, 32'h150, "R8 exc pc untouched");
    rd(3'd0, 32'h0, "R8 ctl untouched");
    rd(3'd4, 32'h0, "R8 flag untouched");

    // R10 trap wins over same-cycle write
    wr(3'd0, 32'h1);
    retire_valid = 1; retire_class = 8'h20; retire_pc = 32'h600;
    reg_wr_en = 1; reg_sel = 3'd3; reg_wdata = 32'hDEAD_BEEF;
    expect_next(K_RV, 1, "R10 collision redirect");
    @(negedge clk);
    idle();
    rd(3'd3, 32'h600, "R10 trap beats write");
    rd(3'd0, 32'h4, "R6 prev bit zero");

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule